// File: doc/BRIEF.md
# Multi-Format Signed Integer Arithmetic Unit

This block operates on W-bit signed integers held in any of three encodings: sign-and-magnitude, ones' complement and two's complement. A single operation code selects what it does with its operands. It can turn a value from either of the other encodings into two's complement, or turn a two's-complement value into a chosen encoding. It can add, subtract or negate two's-complement operands. It can also resize a two's-complement value to a target width between 1 and 2W bits and report whether a narrowing kept the value intact.

Arithmetic overflow comes from two detectors built on different principles. The first compares the carry entering the sign position with the carry leaving it. The second repeats the sign bit once above each operand, adds at W+1 bits and compares the two top bits of that sum. Both flags are brought out, and on a correct unit they are always equal.

The result can leave through an output register (one cycle of latency) or directly from the combinational datapath. A parameter makes that choice.

Top module: `sgn_arith_unit`

## Requirements
- R1: The format code on `fmt_i` is 0 for sign-and-magnitude, 1 for ones' complement, and 2 or 3 for two's complement. With `op_i`=3 the unit converts `a_i` from the selected format to two's complement. A negative sign-and-magnitude value becomes the negation of its magnitude, sign-and-magnitude -0 becomes all zeros, and a two's-complement input passes through unchanged.
- R2: With `op_i`=3 and format 1, a ones'-complement value with bit W-1 set has 1 added to it, so the all-ones pattern (-0) becomes all zeros. A value with bit W-1 clear passes through.
- R3: With `op_i`=4 the unit converts a two's-complement `a_i` to the selected format. A negative value becomes {1, magnitude} for sign-and-magnitude and {1, inverted magnitude} for ones' complement. Non-negative values, and every value under formats 2 and 3, pass through.
- R4: With `op_i`=4 and format 0 or 1, the input {1, 0...0} (-2^(W-1)) has no representation, so `cnv_err_o` is 1 and the result is all zeros.
- R5: `op_i`=0 gives a+b and `op_i`=1 gives a-b, both modulo 2^W. `op_i`=2 gives 2^W-a modulo 2^W. The result sits in bits W-1:0 and the upper bits are zero.
- R6: For operations 0 to 2, `ovf_carry_o` and `ovf_dsign_o` are each 1 exactly when the true signed result lies outside -2^(W-1)..2^(W-1)-1. The two flags are always equal.
- R7: With `op_i`=5 and target width m taken from `tw_i`, result bits m-1:0 hold `a_i` as an m-bit value. When m>W, bits W..m-1 are copies of the sign bit. Bits at m and above are zero.
- R8: With `op_i`=5, `rsz_ok_o` is 1 when m is at least W. When m is below W, it is 1 exactly when every bit of `a_i` from m-1 through W-1 is equal.
- R9: Both overflow flags are 0 for operations other than 0 to 2, `rsz_ok_o` is 0 for operations other than 5, and `cnv_err_o` is 0 for operations other than 4.
- R10: A `tw_i` of 0 acts as m=1, and a `tw_i` above 2W acts as m=2W.
- R11: With REG_OUT=1, all outputs are zero while reset is held, and each result appears one clock edge after its inputs. With REG_OUT=0, the outputs follow the inputs with no clock.
- R12: Operation codes 6 and 7 drive all outputs to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| op_i | input | 3 | Operation code |
| fmt_i | input | 2 | Encoding select for the conversions |
| tw_i | input | $clog2(2W+1) | Target width for resizing |
| a_i | input | W | First operand |
| b_i | input | W | Second operand (add and subtract only) |
| res_o | output | 2W | Result |
| ovf_carry_o | output | 1 | Overflow from the sign-position carry comparison |
| ovf_dsign_o | output | 1 | Overflow from the duplicated-sign sum |
| rsz_ok_o | output | 1 | Resize kept the value |
| cnv_err_o | output | 1 | Value not representable in the target encoding |

## Verification
The unit keeps no state apart from its output register. A fault in a converter, an adder stage or a resizer bit therefore shows up as a wrong result or flag in the very cycle its inputs reach the register, and it reaches the ports one edge later. A fault in only one overflow detector splits the two flags on the first overflowing vector. A wrong sign or carry path produces a wrong result at a boundary pattern such as -2^(W-1), -0 or the top positive value. The sweep at W=4 reaches every such pattern within a few hundred cycles, and the random run at W=8 covers the same points at a width where the magnitude and sign fields are longer.

// File: rtl/sau_pkg.sv
`timescale 1ns/1ps
package sau_pkg;

  typedef enum logic [2:0] {
    OP_ADD    = 3'd0,
    OP_SUB    = 3'd1,
    OP_NEG    = 3'd2,
    OP_TO2C   = 3'd3,
    OP_FROM2C = 3'd4,
    OP_RESIZE = 3'd5,
    OP_RSV6   = 3'd6,
    OP_RSV7   = 3'd7
  } sau_op_e;

  typedef enum logic [1:0] {
    FMT_SM     = 2'd0,
    FMT_OC     = 2'd1,
    FMT_TC     = 2'd2,
    FMT_TC_ALT = 2'd3
  } sau_fmt_e;

endpackage

// File: rtl/sau_addsub.sv
`timescale 1ns/1ps
// Two's-complement add / subtract / negate with two independent overflow detectors.
module sau_addsub #(
  parameter int W = 8
) (
  input  logic [W-1:0] x_i,
  input  logic [W-1:0] y_i,
  input  logic         sub_i,
  input  logic         neg_i,
  output logic [W-1:0] sum_o,
  output logic         ovf_carry_o,
  output logic         ovf_dsign_o
);

  localparam int DW = W + 1;

  logic [W-1:0]  opa, opb, ysel;
  logic          cin;
  logic [W-1:0]  low_ext;
  logic          c_into_sign;
  logic [1:0]    top_ext;
  logic [DW-1:0] dsum;

  // operand selection: negate computes 0 + ~x + 1
  always_comb begin
    ysel = neg_i ? x_i : y_i;
    opa  = neg_i ? '0 : x_i;
    cin  = sub_i | neg_i;
    opb  = cin ? ~ysel : ysel;
  end

  // detector A: ripple split at the sign position, carries compared
  always_comb begin
    low_ext     = {1'b0, opa[W-2:0]} + {1'b0, opb[W-2:0]} + W'(cin);
    c_into_sign = low_ext[W-1];
    top_ext     = {1'b0, opa[W-1]} + {1'b0, opb[W-1]} + {1'b0, c_into_sign};
    sum_o       = {top_ext[0], low_ext[W-2:0]};
    ovf_carry_o = c_into_sign ^ top_ext[1];
  end

  // detector B: one duplicated sign bit, top two sum bits compared
  always_comb begin
    dsum        = {opa[W-1], opa} + {opb[W-1], opb} + DW'(cin);
    ovf_dsign_o = dsum[W] ^ dsum[W-1];
  end

endmodule

// File: rtl/sau_fmt_conv.sv
`timescale 1ns/1ps
// Encoding conversion to and from two's complement.
module sau_fmt_conv
  import sau_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] val_i,
  input  sau_fmt_e     fmt_i,
  output logic [W-1:0] to_tc_o,
  output logic [W-1:0] from_tc_o,
  output logic         err_o
);

  localparam logic [W-1:0] MIN_PAT = {1'b1, {(W-1){1'b0}}};

  logic         sgn;
  logic         is_tc;
  logic [W-1:0] oc_form;
  logic [W-1:0] mag;

  assign sgn   = val_i[W-1];
  assign is_tc = (fmt_i == FMT_TC) || (fmt_i == FMT_TC_ALT);

  // into two's complement: sign-magnitude -> ones' complement -> +1
  always_comb begin
    oc_form = val_i;
    if (sgn && (fmt_i == FMT_SM)) oc_form = {1'b1, ~val_i[W-2:0]};
    to_tc_o = (sgn && !is_tc) ? oc_form + W'(1) : oc_form;
  end

  // out of two's complement
  always_comb begin
    mag       = ~val_i + W'(1);
    from_tc_o = val_i;
    err_o     = 1'b0;
    if (!is_tc && sgn) begin
      if (val_i == MIN_PAT) begin
        err_o     = 1'b1;
        from_tc_o = '0;
      end else if (fmt_i == FMT_SM) begin
        from_tc_o = {1'b1, mag[W-2:0]};
      end else begin
        from_tc_o = {1'b1, ~mag[W-2:0]};
      end
    end
  end

endmodule

// File: rtl/sau_resize.sv
`timescale 1ns/1ps
// Sign-extend or truncate a two's-complement value to m bits (1..RW).
module sau_resize #(
  parameter int W   = 8,
  parameter int RW  = 2 * W,
  parameter int TWW = $clog2(RW + 1)
) (
  input  logic [W-1:0]   val_i,
  input  logic [TWW-1:0] tw_i,
  output logic [RW-1:0]  res_o,
  output logic           ok_o
);

  logic [TWW-1:0] m_sel;
  logic           top_bit;

  always_comb begin
    if (tw_i == '0)               m_sel = TWW'(1);
    else if (tw_i > TWW'(RW))     m_sel = TWW'(RW);
    else                          m_sel = tw_i;
  end

  // one mux per result bit: value bit, sign copy, or zero above m
  for (genvar g = 0; g < RW; g++) begin : g_bit
    if (g < W) begin : g_in
      assign res_o[g] = (m_sel > TWW'(g)) ? val_i[g] : 1'b0;
    end else begin : g_ext
      assign res_o[g] = (m_sel > TWW'(g)) ? val_i[W-1] : 1'b0;
    end
  end

  // narrowing keeps the value only if all dropped bits equal the new sign
  always_comb begin
    top_bit = val_i[W-1];
    for (int i = 0; i < W; i++)
      if (i == int'(m_sel) - 1) top_bit = val_i[i];
    ok_o = 1'b1;
    for (int i = 0; i < W; i++)
      if ((i >= int'(m_sel)) && (val_i[i] != top_bit)) ok_o = 1'b0;
  end

endmodule

// File: rtl/sgn_arith_unit.sv
`timescale 1ns/1ps
module sgn_arith_unit
  import sau_pkg::*;
#(
  parameter  int W       = 8,
  parameter  bit REG_OUT = 1'b1,
  localparam int RW      = 2 * W,
  localparam int TWW     = $clog2(RW + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [2:0]     op_i,
  input  logic [1:0]     fmt_i,
  input  logic [TWW-1:0] tw_i,
  input  logic [W-1:0]   a_i,
  input  logic [W-1:0]   b_i,
  output logic [RW-1:0]  res_o,
  output logic           ovf_carry_o,
  output logic           ovf_dsign_o,
  output logic           rsz_ok_o,
  output logic           cnv_err_o
);

  sau_op_e  op_e;
  sau_fmt_e fmt_e;
  assign op_e  = sau_op_e'(op_i);
  assign fmt_e = sau_fmt_e'(fmt_i);

  logic [W-1:0]  add_sum, to_tc, from_tc;
  logic          add_ovf_c, add_ovf_d, conv_err;
  logic [RW-1:0] rz_res;
  logic          rz_ok;

  sau_addsub #(.W(W)) u_addsub (
    .x_i         (a_i),
    .y_i         (b_i),
    .sub_i       (op_e == OP_SUB),
    .neg_i       (op_e == OP_NEG),
    .sum_o       (add_sum),
    .ovf_carry_o (add_ovf_c),
    .ovf_dsign_o (add_ovf_d)
  );

  sau_fmt_conv #(.W(W)) u_conv (
    .val_i     (a_i),
    .fmt_i     (fmt_e),
    .to_tc_o   (to_tc),
    .from_tc_o (from_tc),
    .err_o     (conv_err)
  );

  sau_resize #(.W(W), .RW(RW), .TWW(TWW)) u_resize (
    .val_i (a_i),
    .tw_i  (tw_i),
    .res_o (rz_res),
    .ok_o  (rz_ok)
  );

  // next-state selection
  logic [RW-1:0] res_d;
  logic          ovf_c_d, ovf_d_d, ok_d, err_d;

  always_comb begin
    res_d   = '0;
    ovf_c_d = 1'b0;
    ovf_d_d = 1'b0;
    ok_d    = 1'b0;
    err_d   = 1'b0;
    unique case (op_e)
      OP_ADD, OP_SUB, OP_NEG: begin
        res_d   = RW'(add_sum);
        ovf_c_d = add_ovf_c;
        ovf_d_d = add_ovf_d;
      end
      OP_TO2C:   res_d = RW'(to_tc);
      OP_FROM2C: begin
        res_d = RW'(from_tc);
        err_d = conv_err;
      end
      OP_RESIZE: begin
        res_d = rz_res;
        ok_d  = rz_ok;
      end
      default: ;
    endcase
  end

  if (REG_OUT) begin : g_reg
    logic [1:0] rst_sync;
    logic       rst_int_n;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rst_sync <= 2'b00;
      else        rst_sync <= {rst_sync[0], 1'b1};
    end
    assign rst_int_n = rst_sync[1];

    always_ff @(posedge clk or negedge rst_int_n) begin
      if (!rst_int_n) begin
        res_o       <= '0;
        ovf_carry_o <= 1'b0;
        ovf_dsign_o <= 1'b0;
        rsz_ok_o    <= 1'b0;
        cnv_err_o   <= 1'b0;
      end else begin
        res_o       <= res_d;
        ovf_carry_o <= ovf_c_d;
        ovf_dsign_o <= ovf_d_d;
        rsz_ok_o    <= ok_d;
        cnv_err_o   <= err_d;
      end
    end
  end else begin : g_comb
    assign res_o       = res_d;
    assign ovf_carry_o = ovf_c_d;
    assign ovf_dsign_o = ovf_d_d;
    assign rsz_ok_o    = ok_d;
    assign cnv_err_o   = err_d;
  end

  // R6
  ovf_agree_chk: assert property (@(posedge clk) disable iff (!rst_n)
    add_ovf_c == add_ovf_d);

  // R4
  cnv_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_d |-> (res_d == '0));

  // R9
  ovf_scope_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(op_e inside {OP_ADD, OP_SUB, OP_NEG}) |-> (!ovf_c_d && !ovf_d_d));

  // R9
  err_scope_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_e != OP_FROM2C) |-> !err_d);

  // R8
  widen_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((op_e == OP_RESIZE) && (int'(tw_i) >= W)) |-> ok_d);

  // R1
  tc_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((op_e == OP_TO2C) && fmt_i[1]) |-> (res_d == RW'(a_i)));

endmodule

// File: tb/tb_sgn_arith_unit.sv
`timescale 1ns/1ps
module tb_sgn_arith_unit;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  // W=4, registered output
  logic [2:0] op4;  logic [1:0] fmt4; logic [3:0] tw4;
  logic [3:0] a4, b4;
  logic [7:0] res4; logic oc4, od4, ok4, er4;

  // W=8, combinational output
  logic [2:0] op8;  logic [1:0] fmt8; logic [4:0] tw8;
  logic [7:0] a8, b8;
  logic [15:0] res8; logic oc8, od8, ok8, er8;

  sgn_arith_unit #(.W(4), .REG_OUT(1'b1)) dut (
    .clk(clk), .rst_n(rst_n), .op_i(op4), .fmt_i(fmt4), .tw_i(tw4),
    .a_i(a4), .b_i(b4), .res_o(res4), .ovf_carry_o(oc4),
    .ovf_dsign_o(od4), .rsz_ok_o(ok4), .cnv_err_o(er4));

  sgn_arith_unit #(.W(8), .REG_OUT(1'b0)) dut8 (
    .clk(clk), .rst_n(rst_n), .op_i(op8), .fmt_i(fmt8), .tw_i(tw8),
    .a_i(a8), .b_i(b8), .res_o(res8), .ovf_carry_o(oc8),
    .ovf_dsign_o(od8), .rsz_ok_o(ok8), .cnv_err_o(er8));

  int nchk = 0;
  int nerr = 0;
  bit done = 1'b0;

  task automatic check(input string tag, input string what, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // integer reference model
  task automatic model(input int w, input int op, input int fmt, input int tw,
                       input int a, input int b,
                       output int res, output int ov, output int ok, output int er);
    int full, half, sa, sb, v, m, hm;
    full = 1 << w; half = 1 << (w - 1);
    res = 0; ov = 0; ok = 0; er = 0;
    sa = (a >= half) ? a - full : a;
    sb = (b >= half) ? b - full : b;
    case (op)
      0, 1, 2: begin
        v   = (op == 0) ? sa + sb : (op == 1) ? sa - sb : -sa;
        ov  = ((v < -half) || (v > half - 1)) ? 1 : 0;
        res = v & (full - 1);
      end
      3: begin
        if (fmt == 0)      v = (a >= half) ? -(a - half) : a;
        else if (fmt == 1) v = (a >= half) ? -((full - 1) - a) : a;
        else               v = sa;
        res = v & (full - 1);
      end
      4: begin
        if (fmt >= 2)          res = a;
        else if (sa == -half)  er = 1;
        else if (sa < 0)       res = (fmt == 0) ? half - sa : (full - 1) + sa;
        else                   res = a;
      end
      5: begin
        m   = (tw == 0) ? 1 : (tw > 2 * w) ? 2 * w : tw;
        hm  = 1 << (m - 1);
        res = sa & ((1 << m) - 1);
        ok  = ((sa >= -hm) && (sa <= hm - 1)) ? 1 : 0;
      end
      default: ;
    endcase
  endtask

  task automatic compare(input int w, input int op, input int fmt, input int tw,
                         input int a, input int b, input int gres,
                         input int goc, input int god, input int gok, input int ger);
    int eres, eov, eok, eer;
    string rtag, otag, ktag, etag, what;
    model(w, op, fmt, tw, a, b, eres, eov, eok, eer);
    $sformat(what, "w=%0d op=%0d fmt=%0d tw=%0d a=%0d b=%0d", w, op, fmt, tw, a, b);
    otag = "R9"; ktag = "R9"; etag = "R9";
    case (op)
      0, 1, 2: begin rtag = "R5"; otag = "R6"; end
      3:       rtag = (fmt == 1) ? "R2" : "R1";
      4:       begin rtag = eer ? "R4" : "R3"; etag = "R4"; end
      5:       begin rtag = (tw == 0 || tw > 2 * w) ? "R10" : "R7"; ktag = "R8"; end
      default: begin rtag = "R12"; otag = "R12"; ktag = "R12"; etag = "R12"; end
    endcase
    check(rtag, {what, " res"}, gres, eres);
    check(otag, {what, " ovf_carry"}, goc, eov);
    check(otag, {what, " ovf_dsign"}, god, eov);
    check("R6", {what, " flags agree"}, god, goc);
    check(ktag, {what, " rsz_ok"}, gok, eok);
    check(etag, {what, " cnv_err"}, ger, eer);
  endtask

  task automatic run4(input int op, input int fmt, input int tw, input int a, input int b);
    op4 = 3'(op); fmt4 = 2'(fmt); tw4 = 4'(tw); a4 = 4'(a); b4 = 4'(b);
    @(negedge clk);
    compare(4, op, fmt, tw, a, b, int'(res4), int'(oc4), int'(od4), int'(ok4), int'(er4));
  endtask

  task automatic run8(input int op, input int fmt, input int tw, input int a, input int b);
    op8 = 3'(op); fmt8 = 2'(fmt); tw8 = 5'(tw); a8 = 8'(a); b8 = 8'(b);
    #1;
    compare(8, op, fmt, tw, a, b, int'(res8), int'(oc8), int'(od8), int'(ok8), int'(er8));
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nerr++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    op4 = '0; fmt4 = '0; tw4 = '0; a4 = '0; b4 = '0;
    op8 = '0; fmt8 = '0; tw8 = '0; a8 = '0; b8 = '0;
    #12;
    // R11 reset state
    check("R11", "reset res", int'(res4), 0);
    check("R11", "reset ovf_carry", int'(oc4), 0);
    check("R11", "reset ovf_dsign", int'(od4), 0);
    check("R11", "reset rsz_ok", int'(ok4), 0);
    check("R11", "reset cnv_err", int'(er4), 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R11 one-edge latency: 3+4 not visible before the edge
    op4 = 3'd0; a4 = 4'd3; b4 = 4'd4;
    #1;
    check("R11", "before edge", int'(res4), 0);
    @(negedge clk);
    check("R11", "after edge", int'(res4), 7);

    // exhaustive sweep at W=4
    for (int op = 0; op < 8; op++) begin
      for (int fmt = 0; fmt < 4; fmt++) begin
        if (fmt != 0 && !(op == 3 || op == 4)) continue;
        for (int tw = 0; tw < 16; tw++) begin
          if (tw != 4 && op != 5) continue;
          for (int a = 0; a < 16; a++) begin
            for (int b = 0; b < 16; b++) begin
              if (b != 0 && !(op == 0 || op == 1)) continue;
              run4(op, fmt, tw, a, b);
            end
          end
        end
      end
    end

    // W=8 corner points
    run8(4, 0, 0, 128, 0);   // R4
    run8(4, 1, 0, 128, 0);   // R4
    run8(3, 0, 0, 128, 0);   // R1 -0
    run8(3, 1, 0, 255, 0);   // R2 -0
    run8(0, 0, 0, 127, 1);   // R6
    run8(1, 0, 0, 128, 1);   // R6
    run8(2, 0, 0, 128, 0);   // R5 R6
    run8(5, 0, 7, 127, 0);   // R8 fails
    run8(5, 0, 7, 192, 0);   // R8 ok
    run8(5, 0, 16, 129, 0);  // R7 widen
    run8(5, 0, 31, 129, 0);  // R10

    // W=8 random
    for (int i = 0; i < 3000; i++) begin
      run8(int'($urandom_range(0, 7)), int'($urandom_range(0, 3)),
           int'($urandom_range(0, 31)), int'($urandom_range(0, 255)),
           int'($urandom_range(0, 255)));
    end

    done = 1'b1;
    summary();
    $finish;
  end

endmodule